// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Slave

This block is the device end of a one-wire, open-drain, bidirectional link with no clock line. The host opens a session with a long low level, called a break. It then sends a command byte, and after that either a data byte to store or a pause in which the slave answers with eight bits of its own. Every bit is a low pulse that starts on a falling edge. The value lies in how long the line stays low: a short low pulse that returns high early carries a 1, and a low held through the data window carries a 0. After the data window the line returns high for a stop section.

All timing comes from the system clock through parameterised cycle counts. The line input passes through a synchronizer. A low-level counter detects breaks in every state. A single bit timer paces both reception and transmission. A state machine sequences the session through these states:
- ST_HUNT: waits for a break.
- ST_BRK: the break has been seen and the line is still low.
- ST_REC: recovery with the line high.
- ST_CMD: receives the command byte.
- ST_WDATA: receives the write data byte.
- ST_TURN: the turnaround pause before replying.
- ST_SEND: transmits the reply.

The state machine moves between these states as follows:
- HUNT→BRK, and any state→BRK, on a break.
- BRK→REC when the line rises.
- REC→CMD once recovery completes.
- REC→HUNT if the line falls early.
- CMD→WDATA on a write command.
- CMD→TURN on a read command.
- WDATA→CMD after the data byte.
- TURN→SEND after the pause.
- SEND→CMD after eight bits.

On the chip side the block drives a plain register port. Writes appear as a one-cycle write strobe carrying the address and data. Reads appear as a one-cycle read strobe with the address, and the read data is captured in that same cycle.

Top module: `pulse_link_slave`

## Requirements
- R1: After reset the slave releases the line (`dq_pull`=0), raises no strobe, and ignores all bit traffic until it has seen a break.
- R2: A low line level held for T_BREAK consecutive synchronized cycles is a break. It aborts any transfer in progress, in any state, and the slave releases the line on the next cycle.
- R3: After a break the line must stay high for T_BREAK_REC cycles before commands are accepted. A low level during recovery sends the slave back to waiting for a new break.
- R4: Each received bit begins with a falling edge. It is sampled T_SAMPLE cycles after the synchronized edge, where a high level gives 1 and a low level gives 0. Bytes are eight bits long and arrive least-significant bit first.
- R5: In the command byte, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6..0 are the register address.
- R6: After a write command followed by eight data bits, `reg_wr_en` pulses for exactly one cycle, with `reg_addr` and `reg_wr_data` holding the received address and byte.
- R7: A write whose address is NUM_REGS or higher produces no write strobe.
- R8: A read command produces a one-cycle `reg_rd_en` with `reg_addr` set. `reg_rd_data` is captured in that cycle, and the slave then enters the turnaround state.
- R9: T_TX_TURN cycles after a read command, the slave sends the captured byte least-significant bit first, one bit every T_TX_BIT cycles. Each bit pulls the line low for T_TX_START cycles to send a 1, or for T_TX_DATA_END cycles to send a 0.
- R10: `dq_pull` is asserted only while transmitting, and never for more than T_TX_DATA_END consecutive cycles.
- R11: When a write or read transaction completes, the slave accepts the next command without a new break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_in | input | 1 | Sensed level of the shared line |
| dq_pull | output | 1 | 1 pulls the line low; 0 releases it |
| reg_addr | output | 7 | Register address from the last command |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data byte |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data, sampled while `reg_rd_en` is high |

## Verification
The bench builds the slave with small cycle counts: T_BREAK=40, T_BREAK_REC=12, T_SAMPLE=14, T_TX_START=4, T_TX_DATA_END=20, T_TX_BIT=32, T_TX_TURN=30 and NUM_REGS=64. With these values a whole session lasts a few hundred cycles. That makes it possible to exercise aborted writes, short recovery, the valid and invalid address boundary at 63 and 64, and back-to-back transactions within a short run. It also lets every transmitted pulse width and bit spacing be measured exactly against T_TX_START, T_TX_DATA_END and T_TX_BIT.

// File: rtl/plink_pkg.sv
package plink_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_BRK,
        ST_REC,
        ST_CMD,
        ST_WDATA,
        ST_TURN,
        ST_SEND
    } plink_state_e;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
endpackage

// File: rtl/plink_sync.sv
module plink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[gi] <= 1'b1;
                    else        pipe[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[gi] <= 1'b1;
                    else        pipe[gi] <= pipe[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= pipe[STAGES-1];
    end

    assign lvl  = pipe[STAGES-1];
    assign fall = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/plink_lowcnt.sv
module plink_lowcnt #(
    parameter int T_BREAK = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic brk_hit
);
    localparam int LW = $clog2(T_BREAK + 1);
    localparam logic [LW-1:0] LIMIT = LW'(T_BREAK);
    localparam logic [LW-1:0] LAST  = LW'(T_BREAK - 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_cnt <= '0;
        else if (lvl)              low_cnt <= '0;
        else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
    end

    assign brk_hit = !lvl && (low_cnt == LAST);
endmodule

// File: rtl/plink_timer.sv
module plink_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pulse_link_slave.sv
module pulse_link_slave
    import plink_pkg::*;
#(
    parameter int NUM_REGS      = 64,
    parameter int SYNC_STAGES   = 2,
    parameter int T_BREAK       = 3000,
    parameter int T_BREAK_REC   = 1000,
    parameter int T_SAMPLE      = 1100,
    parameter int T_TX_START    = 400,
    parameter int T_TX_DATA_END = 1800,
    parameter int T_TX_BIT      = 3300,
    parameter int T_TX_TURN     = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dq_in,
    output logic       dq_pull,
    output logic [6:0] reg_addr,
    output logic       reg_wr_en,
    output logic [7:0] reg_wr_data,
    output logic       reg_rd_en,
    input  logic [7:0] reg_rd_data
);
    localparam int M1   = (T_BREAK_REC > T_SAMPLE) ? T_BREAK_REC : T_SAMPLE;
    localparam int M2   = (T_TX_BIT > T_TX_TURN) ? T_TX_BIT : T_TX_TURN;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXT + 1);

    localparam logic [CW-1:0] REC_END   = CW'(T_BREAK_REC - 1);
    localparam logic [CW-1:0] SAMPLE_AT = CW'(T_SAMPLE);
    localparam logic [CW-1:0] TURN_END  = CW'(T_TX_TURN - 1);
    localparam logic [CW-1:0] BIT_END   = CW'(T_TX_BIT - 1);
    localparam logic [CW-1:0] TX_LOW1   = CW'(T_TX_START);
    localparam logic [CW-1:0] TX_LOW0   = CW'(T_TX_DATA_END);
    localparam logic [ADDR_W:0] NREG    = (ADDR_W+1)'(NUM_REGS);

    plink_state_e state, nstate;

    logic               lvl, fall, brk_hit, tclr;
    logic [CW-1:0]      tcnt;
    logic [2:0]         bcnt;
    logic               rx_busy;
    logic [BYTE_W-1:0]  shreg, txreg;
    logic [ADDR_W-1:0]  addr_q;
    logic               rx_state, sample, last_bit, tx_bit_end;

    plink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dq_in),
        .lvl  (lvl),
        .fall (fall)
    );

    plink_lowcnt #(.T_BREAK(T_BREAK)) u_lowcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (lvl),
        .brk_hit(brk_hit)
    );

    plink_timer #(.W(CW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tclr),
        .cnt  (tcnt)
    );

    assign rx_state   = (state == ST_CMD) || (state == ST_WDATA);
    assign sample     = rx_state && rx_busy && (tcnt == SAMPLE_AT) && !brk_hit;
    assign last_bit   = (bcnt == 3'd7);
    assign tx_bit_end = (state == ST_SEND) && (tcnt == BIT_END) && !brk_hit;

    // next-state and timer restart
    always_comb begin
        nstate = state;
        tclr   = 1'b0;
        if (brk_hit) begin
            nstate = ST_BRK;
        end else begin
            unique case (state)
                ST_HUNT: ;
                ST_BRK: begin
                    if (lvl) begin
                        nstate = ST_REC;
                        tclr   = 1'b1;
                    end
                end
                ST_REC: begin
                    if (!lvl)                nstate = ST_HUNT;
                    else if (tcnt == REC_END) nstate = ST_CMD;
                end
                ST_CMD: begin
                    if (fall) tclr = 1'b1;
                    if (sample && last_bit) begin
                        if (lvl) begin
                            nstate = ST_WDATA;
                        end else begin
                            nstate = ST_TURN;
                            tclr   = 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (fall) tclr = 1'b1;
                    if (sample && last_bit) nstate = ST_CMD;
                end
                ST_TURN: begin
                    if (tcnt == TURN_END) begin
                        nstate = ST_SEND;
                        tclr   = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (tx_bit_end) begin
                        tclr = 1'b1;
                        if (last_bit) nstate = ST_CMD;
                    end
                end
                default: nstate = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nstate;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_busy     <= 1'b0;
            bcnt        <= '0;
            shreg       <= '0;
            txreg       <= '0;
            addr_q      <= '0;
            dq_pull     <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_data <= '0;
            reg_rd_en   <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;

            if (rx_state && fall) rx_busy <= 1'b1;

            if (sample) begin
                rx_busy <= 1'b0;
                shreg   <= {lvl, shreg[BYTE_W-1:1]};
                bcnt    <= bcnt + 3'd1;
                if (last_bit) begin
                    if (state == ST_CMD) begin
                        addr_q <= shreg[BYTE_W-1:1];
                        if (!lvl) reg_rd_en <= 1'b1;
                    end else if ({1'b0, addr_q} < NREG) begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_data <= {lvl, shreg[BYTE_W-1:1]};
                    end
                end
            end

            if (reg_rd_en) txreg <= reg_rd_data;

            if (tx_bit_end) begin
                txreg <= {1'b0, txreg[BYTE_W-1:1]};
                bcnt  <= bcnt + 3'd1;
            end

            dq_pull <= (state == ST_SEND) && !brk_hit &&
                       ((tcnt < TX_LOW1) || ((tcnt < TX_LOW0) && !txreg[0]));

            if (nstate != state) begin
                bcnt    <= '0;
                rx_busy <= 1'b0;
            end
        end
    end

    assign reg_addr = addr_q;
endmodule

// File: rtl/plink_slave_chk.sv
module plink_slave_chk
    import plink_pkg::*;
#(
    parameter int NUM_REGS      = 64,
    parameter int T_TX_DATA_END = 1800
) (
    input logic         clk,
    input logic         rst_n,
    input plink_state_e state,
    input logic         brk_hit,
    input logic         dq_pull,
    input logic         reg_wr_en,
    input logic         reg_rd_en,
    input logic [6:0]   reg_addr
);
    int pull_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pull_run <= 0;
        else if (dq_pull) pull_run <= pull_run + 1;
        else              pull_run <= 0;
    end

    // R2
    brk_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> (state == ST_BRK));

    // R2
    brk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> !dq_pull);

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R7
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (int'(reg_addr) < NUM_REGS));

    // R8
    rd_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (state == ST_TURN));

    // R8
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R10
    pull_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_pull |-> (state == ST_SEND));

    // R10
    pull_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= T_TX_DATA_END);
endmodule

bind pulse_link_slave plink_slave_chk #(
    .NUM_REGS     (NUM_REGS),
    .T_TX_DATA_END(T_TX_DATA_END)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .brk_hit  (brk_hit),
    .dq_pull  (dq_pull),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en),
    .reg_addr (reg_addr)
);

// File: tb/test_pulse_link_slave.sv
module test_pulse_link_slave;
    localparam int CLK_PERIOD = 10;
    localparam int P_BRK = 40, P_REC = 12, P_SMP = 14;
    localparam int P_TX1 = 4, P_TX0 = 20, P_BIT = 32, P_TURN = 30, P_NREG = 64;

    typedef struct {
        bit       is_rd;
        bit [6:0] addr;
        bit [7:0] data;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_pull = 1'b0;
    logic       dq_in, dq_pull, reg_wr_en, reg_rd_en;
    logic [6:0] reg_addr;
    logic [7:0] reg_wr_data, reg_rd_data;

    exp_t     q[$];
    bit [7:0] model   [128];
    bit [7:0] ref_mem [128];
    int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, cyc_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    assign dq_in       = ~(dq_pull | host_pull);
    assign reg_rd_data = model[reg_addr];

    pulse_link_slave #(
        .NUM_REGS(P_NREG), .SYNC_STAGES(2), .T_BREAK(P_BRK),
        .T_BREAK_REC(P_REC), .T_SAMPLE(P_SMP), .T_TX_START(P_TX1),
        .T_TX_DATA_END(P_TX0), .T_TX_BIT(P_BIT), .T_TX_TURN(P_TURN)
    ) i_pulse_link_slave (
        .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .dq_pull(dq_pull),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        host_pull = 1'b1; cyc(4);
        host_pull = !b;   cyc(22);
        host_pull = 1'b0; cyc(10);
    endtask

    task automatic send_byte(input bit [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic do_break(input int rec);
        host_pull = 1'b1; cyc(50);
        host_pull = 1'b0; cyc(rec);
    endtask

    task automatic wr_xact(input bit [6:0] a, input bit [7:0] d);
        exp_t e;
        if (int'(a) < P_NREG) begin
            e.is_rd = 1'b0; e.addr = a; e.data = d;
            q.push_back(e);
            ref_mem[a] = d;
        end
        send_byte({1'b1, a});
        send_byte(d);
        cyc(10);
    endtask

    task automatic rd_xact(input bit [6:0] a);
        exp_t e;
        e.is_rd = 1'b1; e.addr = a; e.data = ref_mem[a];
        q.push_back(e);
        send_byte({1'b0, a});
        cyc(320);
    endtask

    // monitor: register port strobes
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && reg_wr_en) begin
                wr_cnt++;
                if (q.size() == 0 || q[0].is_rd) begin
                    check(1'b0, "R6 unexpected write strobe", reg_addr, 0);
                end else begin
                    check(reg_addr == q[0].addr, "R6 write address", reg_addr, q[0].addr);
                    check(reg_wr_data == q[0].data, "R6 write data", reg_wr_data, q[0].data);
                    model[reg_addr] = reg_wr_data;
                    void'(q.pop_front());
                end
            end
            if (rst_n && reg_rd_en) begin
                rd_cnt++;
                check(q.size() != 0 && q[0].is_rd, "R8 read strobe expected", 1, 0);
                if (q.size() != 0)
                    check(reg_addr == q[0].addr, "R8 read address", reg_addr, q[0].addr);
            end
        end
    end

    // monitor: transmitted bits
    initial begin
        bit       prevp = 1'b0;
        bit [7:0] rx = '0;
        int nb = 0, last_rise = 0, due = -1;
        forever begin
            @(negedge clk);
            if (dq_pull && !prevp) begin
                if (nb > 0)
                    check(cyc_n - last_rise == P_BIT, "R9 bit spacing", cyc_n - last_rise, P_BIT);
                last_rise = cyc_n;
                due = cyc_n + 12;
            end
            if (!dq_pull && prevp)
                check((cyc_n - last_rise == P_TX1) || (cyc_n - last_rise == P_TX0),
                      "R10 pull width", cyc_n - last_rise, P_TX0);
            if (cyc_n == due) begin
                rx = {~dq_pull, rx[7:1]};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (q.size() == 0 || !q[0].is_rd) begin
                        check(1'b0, "R9 unexpected reply", rx, 0);
                    end else begin
                        check(rx == q[0].data, "R9 reply byte", rx, q[0].data);
                        void'(q.pop_front());
                    end
                end
            end
            prevp = dq_pull;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int w0;
        for (int i = 0; i < 128; i++) begin
            model[i]   = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        cyc(5);
        // R1: reset state
        check(dq_pull == 1'b0, "R1 line released in reset", dq_pull, 0);
        check(reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 no strobe in reset", reg_wr_en, 0);
        rst_n = 1'b1;
        cyc(5);

        // R1: traffic before any break is ignored
        send_byte({1'b1, 7'd3});
        send_byte(8'h77);
        send_byte({1'b0, 7'd3});
        cyc(100);
        check(wr_cnt == 0 && rd_cnt == 0, "R1 traffic ignored before break", wr_cnt + rd_cnt, 0);
        check(dq_pull == 1'b0, "R1 no reply before break", dq_pull, 0);

        // R4 R5 R6: writes after a break, back to back (R11)
        do_break(20);
        wr_xact(7'd5, 8'hA5);
        check(q.size() == 0, "R6 write to addr 5 seen", q.size(), 0);
        wr_xact(7'd63, 8'h3C);
        check(q.size() == 0, "R11 second write without break", q.size(), 0);

        // R7: invalid addresses ignored
        w0 = wr_cnt;
        wr_xact(7'd64, 8'hFF);
        wr_xact(7'd127, 8'h01);
        check(wr_cnt == w0, "R7 invalid address writes ignored", wr_cnt, w0);

        // R8 R9: reads
        rd_xact(7'd5);
        check(q.size() == 0, "R9 read of addr 5 returned", q.size(), 0);
        rd_xact(7'd63);
        rd_xact(7'd10);
        check(q.size() == 0, "R11 reads back to back", q.size(), 0);
        check(rd_cnt == 3, "R8 read strobe count", rd_cnt, 3);
        check(dq_pull == 1'b0, "R10 line released after reply", dq_pull, 0);

        // R2: break aborts a half-received write
        w0 = wr_cnt;
        send_byte({1'b1, 7'd7});
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        do_break(20);
        check(wr_cnt == w0, "R2 aborted write produced no strobe", wr_cnt, w0);
        check(dq_pull == 1'b0, "R2 line released after break", dq_pull, 0);
        wr_xact(7'd7, 8'h81);
        check(q.size() == 0 && wr_cnt == w0 + 1, "R2 clean write after abort", wr_cnt, w0 + 1);

        // R3: short recovery returns to hunting
        w0 = wr_cnt;
        do_break(5);
        send_byte({1'b1, 7'd9});
        send_byte(8'h11);
        cyc(50);
        check(wr_cnt == w0, "R3 short recovery ignores command", wr_cnt, w0);
        do_break(20);
        wr_xact(7'd9, 8'h11);
        rd_xact(7'd9);
        check(q.size() == 0, "R3 full recovery accepts command", q.size(), 0);
        rd_xact(7'd7);
        check(q.size() == 0, "R4 read back pattern 81", q.size(), 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule